// File: doc/BRIEF.md
# Dual Cascadable Interval Timers

This block holds two 16-bit down-counters, timer A and timer B. Each has a reload latch and a control byte, and both are reached through a byte-wide register port. A counter decrements on every tick of its selected source. When a tick arrives while the counter is already zero, the timer underflows. On underflow it reloads from its latch and raises a one-cycle pulse on its interrupt source line. In continuous operation it then keeps running. In one-shot operation it stops itself.

Timer A ticks on every system clock, or on rising edges of the external count input `cnt_in`. That input passes through a two-flop synchronizer before the edge is detected. Timer B picks one of four sources: the system clock, `cnt_in` edges, timer A underflows, or timer A underflows taken only while the synchronized `cnt_in` is high. The cascade is a chain: an underflow of A is counted by B on the same clock edge.

Each timer runs a two-state machine. In `T_STOPPED` the counter holds. It changes only through a latch high-byte write or a control write. A control write with the start bit set (start transition) moves the timer to `T_RUNNING`, where it decrements on each tick. Two transitions lead back to `T_STOPPED`. The stop transition is a control write with the start bit clear. The one-shot transition is an underflow with the one-shot bit set. Both transitions leave the counter holding the latch value.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, all four counter byte registers read 0xFF, both control registers read 0x00 and `irq_src` is 0.
- R2: Offsets 0x4/0x5 read timer A counter low/high bytes and offsets 0x6/0x7 read timer B counter low/high bytes. Writes to those offsets go to the latch. Offsets 0xE/0xF read back the timer A/B control bytes. Offset 0x0 reads 0x00.
- R3: A latch high-byte write to a stopped timer copies the whole latch into the counter. A latch low-byte write never changes the counter. A high-byte write to a running timer leaves the counter alone.
- R4: Control bit 4 is a load strobe. It copies the latch into the counter and always reads back as 0.
- R5: In clock mode, a timer whose counter holds N when the control write with start bit 0 = 1 occurs gives its `irq_src` pulse exactly N+1 clocks after that write. The pulse lasts one clock.
- R6: In continuous mode (control bit 3 = 0), the timer reloads on underflow and keeps pulsing with period N+1 clocks.
- R7: In one-shot mode (control bit 3 = 1), an underflow clears the start bit and leaves the counter equal to the latch.
- R8: Writing the control byte with the start bit clear reloads the counter from the latch.
- R9: With timer A control bit 5 = 1, timer A counts rising edges of `cnt_in` and ignores the clock.
- R10: Timer B source bits 6:5 select the tick source. 01 counts `cnt_in` rising edges. 10 counts timer A underflows. 11 counts timer A underflows only while `cnt_in` is high.
- R11: `irq_src[0]` is timer A's underflow pulse and `irq_src[1]` is timer B's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe for the byte on `wr_data` |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| cnt_in | input | 1 | External count input, asynchronous |
| irq_src | output | 2 | Underflow pulses: bit 0 timer A, bit 1 timer B |

## Verification
The clock-mode tests start timer A with a small count and log the cycle of every pulse. An off-by-one in the start, tick or reload path shows up as a shifted pulse. One-shot and continuous runs with the same count separate self-stop from reload. The `cnt_in` pulse trains check counting by events; a leak of clock ticks into event mode would show as an extra decrement. Cascade tests run timer A with a short period. The ungated run shows whether B counts A's underflows at all. The gated run holds `cnt_in` low, then high, to separate source 11 from source 10.

// File: rtl/dit_pkg.sv
package dit_pkg;
    typedef enum logic {
        T_STOPPED = 1'b0,
        T_RUNNING = 1'b1
    } tmr_state_t;

    localparam logic [3:0] OFS_A_LO  = 4'h4;
    localparam logic [3:0] OFS_A_HI  = 4'h5;
    localparam logic [3:0] OFS_B_LO  = 4'h6;
    localparam logic [3:0] OFS_B_HI  = 4'h7;
    localparam logic [3:0] OFS_A_CTL = 4'hE;
    localparam logic [3:0] OFS_B_CTL = 4'hF;

    localparam int CTL_START   = 0;
    localparam int CTL_ONESHOT = 3;
    localparam int CTL_FORCE   = 4;
    localparam int CTL_SRC_LO  = 5;
    localparam int CTL_SRC_HI  = 6;
endpackage

// File: rtl/dit_cnt_sync.sv
module dit_cnt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_in,
    output logic cnt_level,
    output logic cnt_rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], cnt_in};
    end

    always_comb begin
        cnt_level = sh_q[STAGES-1];
        cnt_rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
    end
endmodule

// File: rtl/dit_timer.sv
module dit_timer
    import dit_pkg::*;
#(
    parameter int W       = 16,
    parameter bit CASCADE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic         wr_ctl,
    input  logic [7:0]   wdata,
    input  logic         cnt_rise,
    input  logic         cnt_level,
    input  logic         casc_evt,
    output logic [W-1:0] count,
    output logic [7:0]   ctrl_rd,
    output logic         uf_evt
);
    localparam int HI_W = W - 8;

    tmr_state_t   state_q, state_d;
    logic [W-1:0] latch_q, count_q;
    logic [7:0]   ctl_q;
    logic         tick;
    logic         running;

    assign running = (state_q == T_RUNNING);

    generate
        if (CASCADE) begin : g_src_b
            always_comb begin
                unique case (ctl_q[CTL_SRC_HI:CTL_SRC_LO])
                    2'b00:   tick = 1'b1;
                    2'b01:   tick = cnt_rise;
                    2'b10:   tick = casc_evt;
                    default: tick = casc_evt & cnt_level;
                endcase
            end
            logic unused_b;
            assign unused_b = ctl_q[7];
        end else begin : g_src_a
            assign tick = ctl_q[CTL_SRC_LO] ? cnt_rise : 1'b1;
            logic unused_a;
            assign unused_a = &{1'b0, casc_evt, cnt_level, ctl_q[7:6]};
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= T_STOPPED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_STOPPED: if (wr_ctl && wdata[CTL_START]) state_d = T_RUNNING;
            T_RUNNING: begin
                if (wr_ctl && !wdata[CTL_START])     state_d = T_STOPPED;
                else if (uf_evt && ctl_q[CTL_ONESHOT]) state_d = T_STOPPED;
            end
            default: state_d = T_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        uf_evt  = running && tick && (count_q == '0) && !wr_ctl;
        ctrl_rd = ctl_q | {7'b0, running};
        count   = count_q;
    end

    // latch and control byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
            ctl_q   <= '0;
        end else begin
            if (wr_lo)  latch_q[7:0]   <= wdata;
            if (wr_hi)  latch_q[W-1:8] <= wdata[HI_W-1:0];
            if (wr_ctl) ctl_q <= {wdata[7:5], 1'b0, wdata[3:1], 1'b0};
        end
    end

    // counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '1;
        end else if (wr_ctl) begin
            if (wdata[CTL_FORCE] || !wdata[CTL_START]) count_q <= latch_q;
        end else if (wr_hi && !running) begin
            count_q <= {wdata[HI_W-1:0], latch_q[7:0]};
        end else if (uf_evt) begin
            count_q <= latch_q;
        end else if (running && tick) begin
            count_q <= count_q - 1'b1;
        end
    end

    assert_uf_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> count_q == $past(latch_q));

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_evt && ctl_q[CTL_ONESHOT]) |=> state_q == T_STOPPED);

    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !wr_hi && !wr_ctl) |=> $stable(count_q));

    assert_tick_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !wr_ctl && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

    assert_stop_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !wdata[CTL_START]) |=> count_q == $past(latch_q));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int W          = 16,
    parameter int SYNC_FLOPS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       cnt_in,
    output logic [1:0] irq_src
);
    logic         cnt_level, cnt_rise;
    logic [W-1:0] count_a, count_b;
    logic [7:0]   ctl_a, ctl_b;
    logic         uf_a, uf_b;
    logic [1:0]   irq_q;

    dit_cnt_sync #(.STAGES(SYNC_FLOPS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_in    (cnt_in),
        .cnt_level (cnt_level),
        .cnt_rise  (cnt_rise)
    );

    dit_timer #(.W(W), .CASCADE(1'b0)) u_tmr_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_en && addr == OFS_A_LO),
        .wr_hi     (wr_en && addr == OFS_A_HI),
        .wr_ctl    (wr_en && addr == OFS_A_CTL),
        .wdata     (wr_data),
        .cnt_rise  (cnt_rise),
        .cnt_level (cnt_level),
        .casc_evt  (1'b0),
        .count     (count_a),
        .ctrl_rd   (ctl_a),
        .uf_evt    (uf_a)
    );

    dit_timer #(.W(W), .CASCADE(1'b1)) u_tmr_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (wr_en && addr == OFS_B_LO),
        .wr_hi     (wr_en && addr == OFS_B_HI),
        .wr_ctl    (wr_en && addr == OFS_B_CTL),
        .wdata     (wr_data),
        .cnt_rise  (cnt_rise),
        .cnt_level (cnt_level),
        .casc_evt  (uf_a),
        .count     (count_b),
        .ctrl_rd   (ctl_b),
        .uf_evt    (uf_b)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= {uf_b, uf_a};
    end

    always_comb begin
        irq_src = irq_q;
        unique case (addr)
            OFS_A_LO:  rd_data = count_a[7:0];
            OFS_A_HI:  rd_data = count_a[W-1:8];
            OFS_B_LO:  rd_data = count_b[7:0];
            OFS_B_HI:  rd_data = count_b[W-1:8];
            OFS_A_CTL: rd_data = ctl_a;
            OFS_B_CTL: rd_data = ctl_b;
            default:   rd_data = 8'h00;
        endcase
    end

    assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_src[0] |=> !irq_src[0] || $past(count_a) == '0);
endmodule

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cnt_in = 1'b0;
    logic [1:0] irq_src;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_interval_timer u_dual_interval_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .cnt_in(cnt_in), .irq_src(irq_src)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        chk(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic cnt_pulse();
        @(negedge clk); cnt_in = 1'b1;
        repeat (2) @(negedge clk);
        cnt_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk(4'h4, 8'hFF, "R1 a_lo");
        rd_chk(4'h5, 8'hFF, "R1 a_hi");
        rd_chk(4'h6, 8'hFF, "R1 b_lo");
        rd_chk(4'h7, 8'hFF, "R1 b_hi");
        rd_chk(4'hE, 8'h00, "R1 a_ctl");
        rd_chk(4'hF, 8'h00, "R1 b_ctl");
        chk(irq_src == 2'b00, "R1 irq", irq_src, 0);
    endtask

    task automatic t_regmap();
        wr(4'h4, 8'h34);
        rd_chk(4'h4, 8'hFF, "R3 low write keeps counter");
        wr(4'h5, 8'h12);
        rd_chk(4'h4, 8'h34, "R2 R3 a_lo after high write");
        rd_chk(4'h5, 8'h12, "R2 R3 a_hi after high write");
        rd_chk(4'h0, 8'h00, "R2 offset 0");
    endtask

    task automatic t_force();
        wr(4'h6, 8'h10); wr(4'h7, 8'h00);
        rd_chk(4'h6, 8'h10, "R2 b_lo");
        wr(4'hF, 8'h21);
        wr(4'h6, 8'h55); wr(4'h7, 8'h00);
        rd_chk(4'h6, 8'h10, "R3 running high write ignored");
        wr(4'hF, 8'h31);
        rd_chk(4'h6, 8'h55, "R4 force load");
        rd_chk(4'hF, 8'h21, "R4 strobe reads 0");
        wr(4'hF, 8'h00);
    endtask

    task automatic t_oneshot();
        int first = -1;
        int pulses = 0;
        wr(4'h4, 8'h05); wr(4'h5, 8'h00);
        wr(4'hE, 8'h09);
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            if (irq_src[0]) begin
                pulses++;
                if (first < 0) first = k;
            end
        end
        chk(first == 6, "R5 R11 underflow cycle", first, 6);
        chk(pulses == 1, "R5 R7 single pulse", pulses, 1);
        rd_chk(4'hE, 8'h08, "R7 start bit cleared");
        rd_chk(4'h4, 8'h05, "R7 counter equals latch");
    endtask

    task automatic t_continuous();
        int miss = 0;
        wr(4'h4, 8'h03); wr(4'h5, 8'h00);
        wr(4'hE, 8'h01);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (irq_src[0] != ((k % 4) == 0)) miss++;
        end
        chk(miss == 0, "R6 period N+1", miss, 0);
        repeat (2) @(negedge clk);
        rd_chk(4'h4, 8'h01, "R6 mid-count value");
        wr(4'hE, 8'h00);
        rd_chk(4'h4, 8'h03, "R8 stop reloads");
    endtask

    task automatic t_cnt_a();
        wr(4'h4, 8'h0A); wr(4'h5, 8'h00);
        wr(4'hE, 8'h21);
        repeat (4) cnt_pulse();
        repeat (4) @(negedge clk);
        rd_chk(4'h4, 8'h06, "R9 counts cnt edges");
        wr(4'hE, 8'h00);
    endtask

    task automatic t_cnt_b();
        wr(4'h6, 8'h09); wr(4'h7, 8'h00);
        wr(4'hF, 8'h21);
        repeat (3) cnt_pulse();
        repeat (4) @(negedge clk);
        rd_chk(4'h6, 8'h06, "R10 source 01 cnt edges");
        wr(4'hF, 8'h00);
    endtask

    task automatic t_cascade();
        int pa = 0;
        int pb = 0;
        int both = 0;
        wr(4'h4, 8'h02); wr(4'h5, 8'h00);
        wr(4'h6, 8'h01); wr(4'h7, 8'h00);
        wr(4'hF, 8'h41);
        wr(4'hE, 8'h01);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (irq_src[0]) pa++;
            if (irq_src[1]) pb++;
            if (irq_src == 2'b11) both++;
        end
        chk(pa == 4, "R10 cascade A pulses", pa, 4);
        chk(pb == 2, "R10 R11 cascade B pulses", pb, 2);
        chk(both == 2, "R10 B aligned with A", both, 2);
        wr(4'hE, 8'h00); wr(4'hF, 8'h00);
    endtask

    task automatic t_gated();
        int pa = 0;
        int pb = 0;
        wr(4'h4, 8'h01); wr(4'h5, 8'h00);
        wr(4'h6, 8'h00); wr(4'h7, 8'h00);
        wr(4'hF, 8'h61);
        wr(4'hE, 8'h01);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (irq_src[1]) pb++;
        end
        chk(pb == 0, "R10 gate low blocks B", pb, 0);
        rd_chk(4'h6, 8'h00, "R10 gate low B held");
        cnt_in = 1'b1;
        repeat (4) @(negedge clk);
        pb = 0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (irq_src[0]) pa++;
            if (irq_src[1]) pb++;
        end
        chk(pa == 4 && pb == 4, "R10 gate high passes", pb, 4);
        wr(4'hE, 8'h00); wr(4'hF, 8'h00);
        cnt_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_force();
        t_oneshot();
        t_continuous();
        t_cnt_a();
        t_cnt_b();
        t_cascade();
        t_gated();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule